// File: doc/BRIEF.md
# CAN Frame Timestamp Capture Unit

This block timestamps CAN frames. The CAN receiver raises a one-cycle strobe when a frame's end-of-frame field has completed with no error. The node's own transmitted frames come back through its receive path, so they raise the same strobe. The block answers the strobe with a link pulse that lasts one CAN bit time, counted in bit-time ticks. A link-enable control bit gates this pulse on its way to a rising-edge capture channel.

The capture channel runs beside a free-running timer that advances on every system clock. On each rising edge of the gated link signal, the channel latches the timer count as the frame's stamp and raises a pending flag. The flag holds until the consumer acknowledges it. If a capture lands while the flag is still set, the stored stamp is overwritten and an overrun flag is raised.

Top module: `frame_stamp_unit`

## Requirements
- R1: While `rst` is sampled high on a clock edge, the timer, the stored stamp, the pulse state and both flags clear to zero. After release, `link_out`, `cap_stamp`, `cap_pending` and `cap_overrun` read zero until a frame is captured.
- R2: An `eof_ok` strobe sampled while no pulse is active starts the internal link pulse on the next clock cycle. This applies to received and self-transmitted frames alike.
- R3: The pulse stays high through the clock cycle that carries its `PULSE_BITS`-th `bit_tick`, counting ticks from the first cycle the pulse is high. It is low from the following cycle on.
- R4: An `eof_ok` strobe that arrives while a pulse is active is ignored. The pulse is neither restarted nor lengthened.
- R5: `link_out` equals the pulse only while `link_en` is 1. In any cycle where `link_en` is 0, `link_out` is 0 in that same cycle.
- R6: Once `link_en` has been seen low during a pulse, `link_out` stays low for the rest of that pulse, even if `link_en` returns to 1.
- R7: The timer starts from 0 after reset, adds one on every clock and wraps from all ones to zero. On a rising edge of `link_out`, `cap_stamp` takes the timer value of that cycle, visible from the next cycle.
- R8: A capture sets `cap_pending` from the next cycle. The flag then stays 1 until a cycle in which `cap_ack` is 1 and no capture occurs.
- R9: If a capture occurs while `cap_pending` is 1 and `cap_ack` is 0, the stamp is overwritten and `cap_overrun` becomes 1 from the next cycle.
- R10: `cap_ack` clears both flags on the next cycle. If a capture happens in the same cycle as `cap_ack`, the capture takes precedence: `cap_pending` becomes 1 and `cap_overrun` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle strobe per CAN bit time |
| eof_ok | input | 1 | One-cycle strobe: frame finished end-of-frame without error |
| link_en | input | 1 | Routes the link pulse to the capture channel when 1 |
| cap_ack | input | 1 | Acknowledges the pending stamp |
| link_out | output | 1 | Gated link pulse feeding the capture channel |
| cap_stamp | output | TIMER_W | Timer value latched at the last capture |
| cap_pending | output | 1 | A stamp is waiting for acknowledge |
| cap_overrun | output | 1 | A stamp was overwritten before acknowledge |

## Verification
The bench builds the unit with `TIMER_W` = 10 and `PULSE_BITS` = 3. The narrow timer wraps every 1024 cycles, so stamps taken across the all-ones-to-zero boundary can be checked within a short run. A three-tick pulse leaves room for strobes to arrive mid-pulse, for the enable to drop and return inside one pulse, and for tick and strobe to land in the same cycle. Directed phases cover each of these cases and are followed by a long stretch of random strobes, enables, acknowledges and tick rates.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  typedef enum logic {
    LINK_IDLE   = 1'b0,
    LINK_ACTIVE = 1'b1
  } link_state_t;

  typedef struct packed {
    logic pending;
    logic overrun;
  } cap_flags_t;
endpackage

// File: rtl/fsu_free_timer.sv
module fsu_free_timer #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  output logic [TIMER_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end

  assert_timer_step_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> count == TIMER_W'($past(count) + 1'b1));
endmodule

// File: rtl/fsu_pulse_gen.sv
module fsu_pulse_gen
  import fsu_pkg::*;
#(
  parameter int PULSE_BITS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic eof_ok,
  output logic pulse
);
  localparam int CNT_W = (PULSE_BITS > 1) ? $clog2(PULSE_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(PULSE_BITS - 1);

  link_state_t      state;
  logic [CNT_W-1:0] ticks;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LINK_IDLE;
      ticks <= '0;
    end else begin
      case (state)
        LINK_IDLE: begin
          if (eof_ok) begin
            state <= LINK_ACTIVE;
            ticks <= '0;
          end
        end
        LINK_ACTIVE: begin
          if (bit_tick) begin
            if (ticks == LAST_TICK) begin
              state <= LINK_IDLE;
              ticks <= '0;
            end else begin
              ticks <= ticks + 1'b1;
            end
          end
        end
        default: state <= LINK_IDLE;
      endcase
    end
  end

  assign pulse = (state == LINK_ACTIVE);

  assert_pulse_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!pulse && eof_ok) |=> pulse);

  assert_pulse_end_R3: assert property (@(posedge clk) disable iff (rst)
    (pulse && bit_tick && ticks == LAST_TICK) |=> !pulse);

  assert_no_retrigger_R4: assert property (@(posedge clk) disable iff (rst)
    (pulse && eof_ok && !bit_tick) |=> (pulse && $stable(ticks)));
endmodule

// File: rtl/fsu_link_gate.sv
module fsu_link_gate (
  input  logic clk,
  input  logic rst,
  input  logic pulse,
  input  logic link_en,
  output logic link_out
);
  // Latches that the enable dropped during the running pulse.
  logic blocked;

  always_ff @(posedge clk) begin
    if (rst) blocked <= 1'b0;
    else     blocked <= pulse & (blocked | ~link_en);
  end

  assign link_out = pulse & link_en & ~blocked;

  assert_gate_low_R5: assert property (@(posedge clk) disable iff (rst)
    !link_en |-> !link_out);

  assert_no_reedge_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(link_out) |-> $rose(pulse));
endmodule

// File: rtl/fsu_stamp_capture.sv
module fsu_stamp_capture
  import fsu_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig,
  input  logic [TIMER_W-1:0] timer_val,
  input  logic               ack,
  output logic [TIMER_W-1:0] stamp,
  output cap_flags_t         flags
);
  logic trig_d;
  logic rise;

  assign rise = trig & ~trig_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_d <= 1'b0;
      stamp  <= '0;
      flags  <= '0;
    end else begin
      trig_d <= trig;
      if (rise) begin
        stamp         <= timer_val;
        flags.pending <= 1'b1;
        flags.overrun <= flags.pending & ~ack;
      end else if (ack) begin
        flags.pending <= 1'b0;
        flags.overrun <= 1'b0;
      end
    end
  end

  assert_capture_value_R7: assert property (@(posedge clk) disable iff (rst)
    rise |=> stamp == $past(timer_val));

  assert_pending_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (flags.pending && !ack) |=> flags.pending);

  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (rst)
    (rise && flags.pending && !ack) |=> flags.overrun);

  assert_ack_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (ack && !rise) |=> (!flags.pending && !flags.overrun));
endmodule

// File: rtl/frame_stamp_unit.sv
module frame_stamp_unit
  import fsu_pkg::*;
#(
  parameter int TIMER_W    = 16,
  parameter int PULSE_BITS = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_tick,
  input  logic               eof_ok,
  input  logic               link_en,
  input  logic               cap_ack,
  output logic               link_out,
  output logic [TIMER_W-1:0] cap_stamp,
  output logic               cap_pending,
  output logic               cap_overrun
);
  logic [TIMER_W-1:0] timer_count;
  logic               raw_pulse;
  logic               gated;
  cap_flags_t         flags;

  fsu_free_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .count (timer_count)
  );

  fsu_pulse_gen #(.PULSE_BITS(PULSE_BITS)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .eof_ok   (eof_ok),
    .pulse    (raw_pulse)
  );

  fsu_link_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .pulse    (raw_pulse),
    .link_en  (link_en),
    .link_out (gated)
  );

  fsu_stamp_capture #(.TIMER_W(TIMER_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .trig      (gated),
    .timer_val (timer_count),
    .ack       (cap_ack),
    .stamp     (cap_stamp),
    .flags     (flags)
  );

  assign link_out    = gated;
  assign cap_pending = flags.pending;
  assign cap_overrun = flags.overrun;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!cap_pending && !cap_overrun && cap_stamp == '0));
endmodule

// File: tb/test_frame_stamp_unit.sv
module test_frame_stamp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int TW         = 10;
  localparam int PB         = 3;
  localparam int TMOD       = 1 << TW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bit_tick = 1'b0;
  logic          eof_ok = 1'b0;
  logic          link_en = 1'b1;
  logic          cap_ack = 1'b0;
  logic          link_out;
  logic [TW-1:0] cap_stamp;
  logic          cap_pending;
  logic          cap_overrun;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    tick_div = 4;
  int    tick_phase = 0;
  bit    done = 0;
  string phase = "R1";

  // behavioural reference state
  int m_timer = 0, m_ticks = 0, m_stamp = 0;
  bit m_active = 0, m_blocked = 0, m_prev = 0, m_pend = 0, m_ovr = 0;

  frame_stamp_unit #(.TIMER_W(TW), .PULSE_BITS(PB)) i_frame_stamp_unit (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .eof_ok(eof_ok),
    .link_en(link_en), .cap_ack(cap_ack), .link_out(link_out),
    .cap_stamp(cap_stamp), .cap_pending(cap_pending), .cap_overrun(cap_overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit model_link();
    return m_active && link_en && !m_blocked;
  endfunction

  always @(posedge clk) begin
    bit lk, rise;
    lk = model_link();
    rise = lk && !m_prev;
    if (rst) begin
      m_timer = 0; m_ticks = 0; m_stamp = 0;
      m_active = 0; m_blocked = 0; m_prev = 0; m_pend = 0; m_ovr = 0;
    end else begin
      m_blocked = m_active && (m_blocked || !link_en);
      m_prev = lk;
      if (rise) begin
        m_stamp = m_timer;
        m_ovr = m_pend && !cap_ack;
        m_pend = 1;
      end else if (cap_ack) begin
        m_pend = 0; m_ovr = 0;
      end
      if (!m_active) begin
        if (eof_ok) begin m_active = 1; m_ticks = 0; end
      end else if (bit_tick) begin
        m_ticks++;
        if (m_ticks == PB) begin m_active = 0; m_ticks = 0; end
      end
      m_timer = (m_timer + 1) % TMOD;
    end
  end

  // tick source, driven just after the edge
  always @(posedge clk) begin
    #1;
    tick_phase = (tick_phase + 1) % tick_div;
    bit_tick = (tick_phase == 0);
  end

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(phase, "link_out", int'(link_out), int'(model_link()));
      chk(phase, "cap_stamp", int'(cap_stamp), m_stamp);
      chk(phase, "cap_pending", int'(cap_pending), int'(m_pend));
      chk(phase, "cap_overrun", int'(cap_overrun), int'(m_ovr));
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic frame();
    eof_ok = 1'b1; cyc(1); eof_ok = 1'b0;
  endtask

  task automatic ack();
    cap_ack = 1'b1; cyc(1); cap_ack = 1'b0;
  endtask

  initial begin
    int cycles = 0;
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1: everything clear after reset
    chk("R1", "reset link_out", int'(link_out), 0);
    chk("R1", "reset stamp", int'(cap_stamp), 0);
    chk("R1", "reset pending", int'(cap_pending), 0);
    chk("R1", "reset overrun", int'(cap_overrun), 0);
    cyc(5);

    phase = "R2"; frame(); cyc(1);
    @(negedge clk); chk("R2", "pulse after strobe", int'(link_out), 1);
    phase = "R3"; cyc(20); ack(); cyc(3);

    phase = "R4"; frame(); cyc(2); frame(); cyc(1); frame(); cyc(20); ack(); cyc(2);

    phase = "R5"; link_en = 1'b0; frame(); cyc(20); link_en = 1'b1; cyc(2);

    phase = "R6"; frame(); cyc(1); link_en = 1'b0; cyc(2); link_en = 1'b1;
    @(negedge clk); chk("R6", "no new edge", int'(link_out), 0);
    cyc(20); ack(); cyc(2);

    phase = "R9"; frame(); cyc(20); frame(); cyc(20);
    phase = "R8"; cyc(10); ack(); cyc(3);

    phase = "R10"; frame(); cyc(20);
    frame(); cap_ack = 1'b1; cyc(1); cap_ack = 1'b0; cyc(20); ack(); cyc(2);

    phase = "R7";
    for (int k = 0; k < 8; k++) begin frame(); cyc(290); ack(); end

    phase = "R4";
    tick_div = 1;
    for (int k = 0; k < 4; k++) begin frame(); cyc(1); frame(); cyc(4); end
    ack();

    phase = "R9";
    for (int k = 0; k < 3000; k++) begin
      if (k % 500 == 0) tick_div = 1 + ($urandom % 5);
      eof_ok  = ($urandom % 6) == 0;
      link_en = ($urandom % 8) != 0;
      cap_ack = ($urandom % 10) == 0;
      cyc(1);
    end
    eof_ok = 1'b0; cap_ack = 1'b0; link_en = 1'b1;
    cyc(10);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule